// File: doc/BRIEF.md
# AXI Burst Address Generator

This block produces the byte address of every beat in an AXI read or write burst. A requester presents the first address, a 3-bit transfer size code, an 8-bit length code and a 2-bit burst type together with a start pulse. From the next cycle on, the block holds the current beat address and marks the final beat. Each beat-accept pulse moves it to the next address.

Three burst types are handled. In a FIXED burst the address never moves. In an INCR burst the address advances by the transfer size. In a WRAP burst the address advances the same way but folds back to the lower boundary of an aligned window. The window holds all the bytes of the burst.

Requests that cannot be honoured raise an error flag, which stays up for the whole burst. There are two such cases: the reserved type code, and a WRAP burst with an illegal length or an unaligned start. These requests still run to their full beat count as incrementing bursts. The channel handshakes, data, strobes, responses and 4 KB checks belong to the surrounding logic.

Top module: `axi_burst_addr_gen`

## Requirements
- R1: A burst accepted with length code L runs for exactly L+1 accepted beats. `last_o` is high only while the final beat address is presented.
- R2: After the beat pulse that accepts the final beat, `busy_o` is low on the next cycle. A beat pulse while idle has no effect.
- R3: Burst code 2'b00 (FIXED): every beat presents the start address.
- R4: Burst code 2'b01 (INCR): each beat address is the previous one plus 2^size bytes. An unaligned start is not realigned. For example, start 0x00 with size 2 and length 3 gives 0x00, 0x04, 0x08, 0x0C.
- R5: Burst code 2'b10 (WRAP): let T = (L+1)·2^size. The address advances by 2^size, and an address that reaches lower+T is replaced by the lower boundary. The lower boundary is the start rounded down to a multiple of T. For example, 0x44 with size 2 and length 3 gives 0x44, 0x48, 0x4C, 0x40.
- R6: A WRAP request sets `err_o` and runs as INCR in either of two cases: the beat count is not 2, 4, 8 or 16, or the start is not a multiple of 2^size.
- R7: Burst code 2'b11 is reserved. It sets `err_o`, and the burst runs as INCR.
- R8: A start pulse while `busy_o` is high is ignored. The running burst's addresses, last flag and error flag are unchanged.
- R9: During reset `busy_o`, `last_o` and `err_o` are low and `addr_o` is zero.
- R10: `err_o` is updated only when a request is accepted. A legal request clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, taken when idle |
| start_addr_i | input | AW | First beat address |
| size_i | input | 3 | Bytes per beat as a power-of-two code |
| len_i | input | 8 | Beats minus one |
| burst_i | input | 2 | 00 FIXED, 01 INCR, 10 WRAP, 11 reserved |
| beat_i | input | 1 | Current beat accepted, advance |
| busy_o | output | 1 | A burst is in progress; addr_o valid |
| addr_o | output | AW | Current beat address |
| last_o | output | 1 | Current beat is the final one |
| err_o | output | 1 | Accepted request was illegal |

## Verification
The hardest situation to reach is a start request that arrives while a burst is still running and whose fields differ from it. If the block wrongly took it, the damage would show only in later beats. The driver therefore raises a conflicting start, with a different type and an illegal WRAP shape, on the second beat of several bursts. The scoreboard then demands the original addresses, last flags and error flag to the end of the burst. Wrap folding at the first beat and at the last beat is reached with start addresses at the top and in the middle of the window. Beats are spaced with idle cycles, so that holding an address between beats is also covered.

// File: rtl/axi_burst_addr_gen.sv
module axi_burst_addr_gen #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [2:0]    size_i,
  input  logic [7:0]    len_i,
  input  logic [1:0]    burst_i,
  input  logic          beat_i,
  output logic          busy_o,
  output logic [AW-1:0] addr_o,
  output logic          last_o,
  output logic          err_o
);

  localparam logic [1:0] M_FIXED = 2'd0;
  localparam logic [1:0] M_INCR  = 2'd1;
  localparam logic [1:0] M_WRAP  = 2'd2;

  logic [1:0]    mode_q;
  logic [7:0]    left_q;
  logic [AW-1:0] step_q, mask_q, base_q;
  logic [AW-1:0] nxt_addr;
  logic [1:0]    req_mode;

  wire           accept    = start_i && !busy_o;
  wire [AW-1:0]  req_step  = AW'(1) << size_i;
  wire [AW-1:0]  req_beats = AW'(len_i) + AW'(1);
  wire [AW-1:0]  req_mask  = (req_beats << size_i) - AW'(1);
  wire           len_ok    = (len_i == 8'd1) || (len_i == 8'd3) ||
                             (len_i == 8'd7) || (len_i == 8'd15);
  wire           aligned   = (start_addr_i & (req_step - AW'(1))) == '0;
  wire           wrap_ok   = len_ok && aligned;
  wire           req_err   = (burst_i == 2'b11) || ((burst_i == 2'b10) && !wrap_ok);
  wire [AW-1:0]  incr_addr = addr_o + step_q;

  always_comb begin
    if (burst_i == 2'b00)                 req_mode = M_FIXED;
    else if (burst_i == 2'b10 && wrap_ok) req_mode = M_WRAP;
    else                                  req_mode = M_INCR;
  end

  always_comb begin
    case (mode_q)
      M_FIXED: nxt_addr = addr_o;
      M_WRAP:  nxt_addr = base_q | (incr_addr & mask_q);
      default: nxt_addr = incr_addr;
    endcase
  end

  assign last_o = busy_o && (left_q == 8'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      addr_o <= '0;
      err_o  <= 1'b0;
      mode_q <= M_INCR;
      left_q <= '0;
      step_q <= '0;
      mask_q <= '0;
      base_q <= '0;
    end else if (accept) begin
      busy_o <= 1'b1;
      addr_o <= start_addr_i;
      err_o  <= req_err;
      mode_q <= req_mode;
      left_q <= len_i;
      step_q <= req_step;
      mask_q <= req_mask;
      base_q <= start_addr_i & ~req_mask;
    end else if (busy_o && beat_i) begin
      if (left_q == 8'd0) begin
        busy_o <= 1'b0;
      end else begin
        left_q <= left_q - 8'd1;
        addr_o <= nxt_addr;
      end
    end
  end

  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && beat_i && last_o |=> !busy_o); // R2

  AST_FIXED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && beat_i && !last_o && mode_q == M_FIXED |=> $stable(addr_o)); // R3

  AST_INCR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && beat_i && !last_o && mode_q == M_INCR |=>
      addr_o == $past(addr_o) + $past(step_q)); // R4

  AST_WRAP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && mode_q == M_WRAP |-> (addr_o & ~mask_q) == base_q); // R5

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !(beat_i && last_o) |=> busy_o && $stable(err_o) && $stable(mode_q)); // R8

  AST_IDLE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !last_o); // R1

endmodule

// File: tb/tb_axi_burst_addr_gen.sv
module tb_axi_burst_addr_gen;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [2:0]    size_i = '0;
  logic [7:0]    len_i = '0;
  logic [1:0]    burst_i = '0;
  logic          beat_i = 1'b0;
  logic          busy_o, last_o, err_o;
  logic [AW-1:0] addr_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [AW+1:0] expq[$];
  logic [AW-1:0] exp_tag_unused;

  always #5 clk = ~clk;

  axi_burst_addr_gen #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .size_i(size_i), .len_i(len_i), .burst_i(burst_i), .beat_i(beat_i),
    .busy_o(busy_o), .addr_o(addr_o), .last_o(last_o), .err_o(err_o));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: compares each accepted beat against the scoreboard queue
  always @(negedge clk) begin
    #2;
    if (rst_n && busy_o && beat_i) begin
      if (expq.size() == 0) begin
        check("R1 unexpected beat", 64'd1, 64'd0);
      end else begin
        logic [AW+1:0] e;
        e = expq.pop_front();
        check("R3/R4/R5 addr", 64'(addr_o), 64'(e[AW+1:2]));
        check("R1 last", 64'(last_o), 64'(e[1]));
        check("R6/R7/R10 err", 64'(err_o), 64'(e[0]));
      end
    end
  end

  task automatic run_burst(input logic [AW-1:0] a, input logic [2:0] sz,
                           input logic [7:0] ln, input logic [1:0] bt,
                           input bit inject, input int gap);
    logic [AW-1:0] step, tot, msk, lo, cur;
    bit lok, err, wrap;
    int beats;
    step  = AW'(1) << sz;
    beats = int'(ln) + 1;
    tot   = AW'(beats) << sz;
    msk   = tot - 1;
    lo    = a & ~msk;
    lok   = (beats == 2 || beats == 4 || beats == 8 || beats == 16);
    wrap  = (bt == 2'b10) && lok && ((a % step) == 0);
    err   = (bt == 2'b11) || (bt == 2'b10 && !wrap);
    cur   = a;
    for (int i = 0; i < beats; i++) begin
      expq.push_back({cur, (i == beats - 1), err});
      if (bt == 2'b00) cur = cur;
      else if (wrap) begin
        cur = cur + step;
        if (cur == lo + tot) cur = lo;
      end else cur = cur + step;
    end
    @(negedge clk);
    start_i = 1'b1; start_addr_i = a; size_i = sz; len_i = ln; burst_i = bt;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < beats; i++) begin
      for (int g = 0; g < ((i % 2 == 1) ? gap : 0); g++) begin
        beat_i = 1'b0;
        @(negedge clk);
      end
      beat_i = 1'b1;
      if (inject && i == 1) begin
        start_i = 1'b1; start_addr_i = a + 32'h3; size_i = 3'd1;
        len_i = 8'd2; burst_i = 2'b10;
      end
      @(negedge clk);
      start_i = 1'b0;
    end
    beat_i = 1'b0;
    #2;
    check("R2 busy after last", 64'(busy_o), 64'd0);
    check("R1 all beats consumed", 64'(expq.size()), 64'd0);
    expq.delete();
  endtask

  initial begin
    #1;
    check("R9 busy in reset", 64'(busy_o), 64'd0);
    check("R9 last in reset", 64'(last_o), 64'd0);
    check("R9 err in reset", 64'(err_o), 64'd0);
    check("R9 addr in reset", 64'(addr_o), 64'd0);
    #20 rst_n = 1'b1;
    // R2: beat while idle does nothing
    @(negedge clk); beat_i = 1'b1; @(negedge clk); beat_i = 1'b0; #2;
    check("R2 idle beat", 64'(busy_o), 64'd0);
    run_burst(32'h0000_0000, 3'd2, 8'd3, 2'b01, 0, 0);  // R4
    run_burst(32'h0000_0044, 3'd2, 8'd3, 2'b10, 0, 1);  // R5
    run_burst(32'h0000_0100, 3'd3, 8'd2, 2'b00, 1, 2);  // R3, R8
    run_burst(32'h0000_1038, 3'd3, 8'd7, 2'b10, 1, 1);  // R5, R8
    run_burst(32'h0000_000F, 3'd0, 8'd15, 2'b10, 0, 0); // R5 wrap at first step
    run_burst(32'h0000_0040, 3'd2, 8'd2, 2'b10, 1, 0);  // R6 bad length, R8
    run_burst(32'h0000_0042, 3'd2, 8'd1, 2'b10, 0, 1);  // R6 unaligned
    run_burst(32'h0000_0203, 3'd1, 8'd4, 2'b11, 0, 0);  // R7 reserved
    run_burst(32'h0000_0005, 3'd0, 8'd0, 2'b01, 0, 0);  // R10 err clears, single beat
    run_burst(32'hFFFF_FFF8, 3'd2, 8'd3, 2'b01, 0, 0);  // R4 address rolls over
    run_burst(32'h0000_0080, 3'd7, 8'd1, 2'b10, 1, 3);  // R5 two beats of 128 B, R8
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule